// File: doc/BRIEF.md
# DFT Test Mode Decoder

This block sits at the top of a chip's test control and turns a handful of raw test controls into one operating mode. The inputs are a global test-mode qualifier, the scan-enable, a self-test request with a memory/logic target bit, and a small code for the class of boundary instruction that the test access port has already decoded. On every clock the block resolves these controls through a fixed priority into a one-hot mode over six states: functional, scan-shift, capture, memory self-test, logic self-test and boundary-scan. It holds that mode in a register.

From the registered mode alone, the block derives three small select codes for downstream muxing: which clock source to use, how asynchronous reset is handled, and which data path feeds the flops. Because the selects come only from the registered mode, clock, reset and data always change together on a clock edge and never disagree with each other. Functional mode is the home state after reset. A sticky error flag records any overlapping control combination that the priority had to settle.

Top module: `dft_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the mode becomes functional after that edge, `overlap_err_o` becomes 0 and all three selects take their functional codes, whatever the other inputs are.
- R2: With `test_mode_i`=0 sampled, the next mode is functional, regardless of scan-enable, self-test request and boundary code.
- R3: With `test_mode_i`=1 and `bist_en_i`=1 sampled, the next mode is memory self-test when `bist_logic_i`=0 and logic self-test when it is 1. Scan-enable and the boundary code are ignored.
- R4: With `test_mode_i`=1, `bist_en_i`=0 and a non-zero `bnd_cls_i` sampled, the next mode is boundary-scan, regardless of scan-enable.
- R5: With `test_mode_i`=1, `bist_en_i`=0 and `bnd_cls_i`=0 sampled, the next mode is scan-shift when `scan_en_i`=1 and capture when it is 0.
- R6: `mode_oh_o` always has exactly one bit set. Bit positions: 0 functional, 1 scan-shift, 2 capture, 3 memory self-test, 4 logic self-test, 5 boundary-scan.
- R7: Inputs are sampled only at the rising edge. A change between edges leaves all outputs unchanged until the next edge.
- R8: `clk_sel_o` is 0 (functional/at-speed clock) in functional and capture modes, 1 (slow shift clock) in scan-shift, 2 (self-test clock) in both self-test modes, and 3 (test-port clock) in boundary-scan.
- R9: `rst_sel_o` is 0 (functional reset passed) in functional mode, 1 (reset gated off) in scan-shift, capture and both self-test modes, and 2 (reset under test-port control) in boundary-scan.
- R10: `dp_sel_o` is 0 (functional path) in functional and capture modes, 1 (scan chain) in scan-shift, 2 (memory self-test generator) in memory self-test, 3 (pattern generator/signature compactor) in logic self-test, and 4 (boundary cells) in boundary-scan.
- R11: `overlap_err_o` rises after an edge that samples `test_mode_i`=1 and `bist_en_i`=1 together with `scan_en_i`=1 or a non-zero `bnd_cls_i`. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode_i | input | 1 | Global test qualifier; 0 forces functional |
| scan_en_i | input | 1 | Scan-enable: shift (1) or capture (0) |
| bist_en_i | input | 1 | Self-test request |
| bist_logic_i | input | 1 | Self-test target: 0 memory, 1 logic |
| bnd_cls_i | input | BND_W (2) | Decoded boundary instruction class, 0 = none |
| mode_oh_o | output | 6 | Registered one-hot mode |
| clk_sel_o | output | 2 | Clock source select |
| rst_sel_o | output | 2 | Reset handling select |
| dp_sel_o | output | 3 | Data path select |
| overlap_err_o | output | 1 | Sticky overlapping-control flag |

## Verification
The hardest situation to reach is the one the priority exists for: self-test requested together with scan-enable or a boundary instruction. Reaching it must show a single self-test bit, and the flag must then stay set while later inputs are legal. The bench gets there with a full sweep of all 64 control combinations from a clean reset, keeping a running model of the sticky flag. A separate scenario first raises the flag with an overlap, then applies only legal combinations and checks that the flag holds until a reset clears it. Inputs are also changed in the middle of a cycle to show that nothing moves before the next edge.

// File: rtl/dftm_pkg.sv
package dftm_pkg;

  localparam int NUM_MODES = 6;

  // one-hot bit positions of the mode vector
  localparam int M_FUNC  = 0;
  localparam int M_SHIFT = 1;
  localparam int M_CAPT  = 2;
  localparam int M_MBIST = 3;
  localparam int M_LBIST = 4;
  localparam int M_BSCAN = 5;

  typedef enum logic [1:0] {
    CK_FUNC  = 2'd0,
    CK_SHIFT = 2'd1,
    CK_BIST  = 2'd2,
    CK_TCK   = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    RS_PASS  = 2'd0,
    RS_GATED = 2'd1,
    RS_TAP   = 2'd2
  } rst_ctl_e;

  typedef enum logic [2:0] {
    DP_FUNC    = 3'd0,
    DP_SCAN    = 3'd1,
    DP_MEMBIST = 3'd2,
    DP_LOGBIST = 3'd3,
    DP_BOUND   = 3'd4
  } dpath_e;

  function automatic clk_src_e clk_of(input int m);
    case (m)
      M_SHIFT:          return CK_SHIFT;
      M_MBIST, M_LBIST: return CK_BIST;
      M_BSCAN:          return CK_TCK;
      default:          return CK_FUNC;
    endcase
  endfunction

  function automatic rst_ctl_e rst_of(input int m);
    case (m)
      M_SHIFT, M_CAPT, M_MBIST, M_LBIST: return RS_GATED;
      M_BSCAN:                           return RS_TAP;
      default:                           return RS_PASS;
    endcase
  endfunction

  function automatic dpath_e dp_of(input int m);
    case (m)
      M_SHIFT: return DP_SCAN;
      M_MBIST: return DP_MEMBIST;
      M_LBIST: return DP_LOGBIST;
      M_BSCAN: return DP_BOUND;
      default: return DP_FUNC;
    endcase
  endfunction

endpackage

// File: rtl/dftm_resolve.sv
module dftm_resolve
  import dftm_pkg::*;
#(
  parameter int BND_W = 2
) (
  input  logic                 tm,
  input  logic                 se,
  input  logic                 bist_en,
  input  logic                 bist_logic,
  input  logic [BND_W-1:0]     bnd_cls,
  output logic [NUM_MODES-1:0] next_oh,
  output logic                 overlap
);

  logic bnd_act;
  assign bnd_act = |bnd_cls;

  // fixed priority: off-test, self-test, boundary, shift, capture
  always_comb begin
    next_oh = '0;
    if (!tm)          next_oh[M_FUNC]  = 1'b1;
    else if (bist_en) begin
      if (bist_logic) next_oh[M_LBIST] = 1'b1;
      else            next_oh[M_MBIST] = 1'b1;
    end
    else if (bnd_act) next_oh[M_BSCAN] = 1'b1;
    else if (se)      next_oh[M_SHIFT] = 1'b1;
    else              next_oh[M_CAPT]  = 1'b1;
  end

  assign overlap = tm & bist_en & (se | bnd_act);

endmodule

// File: rtl/dftm_state.sv
module dftm_state
  import dftm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_MODES-1:0] next_oh,
  input  logic                 overlap,
  output logic [NUM_MODES-1:0] mode_oh,
  output logic                 err
);

  localparam logic [NUM_MODES-1:0] HOME = NUM_MODES'(1) << M_FUNC;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_oh <= HOME;
      err     <= 1'b0;
    end else begin
      mode_oh <= next_oh;
      err     <= err | overlap;
    end
  end

endmodule

// File: rtl/dftm_cfg_map.sv
module dftm_cfg_map
  import dftm_pkg::*;
(
  input  logic [NUM_MODES-1:0] mode_oh,
  output clk_src_e             clk_src,
  output rst_ctl_e             rst_ctl,
  output dpath_e               dpath
);

  // per-mode contribution, OR-combined; one-hot input means one term wins
  logic [NUM_MODES-1:0][1:0] ck_term;
  logic [NUM_MODES-1:0][1:0] rs_term;
  logic [NUM_MODES-1:0][2:0] dp_term;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    assign ck_term[g] = mode_oh[g] ? clk_of(g) : 2'd0;
    assign rs_term[g] = mode_oh[g] ? rst_of(g) : 2'd0;
    assign dp_term[g] = mode_oh[g] ? dp_of(g)  : 3'd0;
  end

  always_comb begin
    logic [1:0] ck;
    logic [1:0] rs;
    logic [2:0] dp;
    ck = '0;
    rs = '0;
    dp = '0;
    for (int i = 0; i < NUM_MODES; i++) begin
      ck = ck | ck_term[i];
      rs = rs | rs_term[i];
      dp = dp | dp_term[i];
    end
    clk_src = clk_src_e'(ck);
    rst_ctl = rst_ctl_e'(rs);
    dpath   = dpath_e'(dp);
  end

endmodule

// File: rtl/dft_mode_ctrl.sv
module dft_mode_ctrl
  import dftm_pkg::*;
#(
  parameter int BND_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_mode_i,
  input  logic             scan_en_i,
  input  logic             bist_en_i,
  input  logic             bist_logic_i,
  input  logic [BND_W-1:0] bnd_cls_i,
  output logic [5:0]       mode_oh_o,
  output logic [1:0]       clk_sel_o,
  output logic [1:0]       rst_sel_o,
  output logic [2:0]       dp_sel_o,
  output logic             overlap_err_o
);

  logic [NUM_MODES-1:0] next_oh;
  logic                 overlap;
  logic [NUM_MODES-1:0] mode_q;
  clk_src_e             clk_src;
  rst_ctl_e             rst_ctl;
  dpath_e               dpath;

  dftm_resolve #(.BND_W(BND_W)) i_resolve (
    .tm        (test_mode_i),
    .se        (scan_en_i),
    .bist_en   (bist_en_i),
    .bist_logic(bist_logic_i),
    .bnd_cls   (bnd_cls_i),
    .next_oh   (next_oh),
    .overlap   (overlap)
  );

  dftm_state i_state (
    .clk    (clk),
    .rst    (rst),
    .next_oh(next_oh),
    .overlap(overlap),
    .mode_oh(mode_q),
    .err    (overlap_err_o)
  );

  dftm_cfg_map i_map (
    .mode_oh(mode_q),
    .clk_src(clk_src),
    .rst_ctl(rst_ctl),
    .dpath  (dpath)
  );

  assign mode_oh_o = mode_q;
  assign clk_sel_o = clk_src;
  assign rst_sel_o = rst_ctl;
  assign dp_sel_o  = dpath;

endmodule

// File: rtl/dftm_checker.sv
module dftm_checker #(
  parameter int BND_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             test_mode_i,
  input logic             scan_en_i,
  input logic             bist_en_i,
  input logic             bist_logic_i,
  input logic [BND_W-1:0] bnd_cls_i,
  input logic [5:0]       mode_oh_o,
  input logic [1:0]       clk_sel_o,
  input logic [1:0]       rst_sel_o,
  input logic [2:0]       dp_sel_o,
  input logic             overlap_err_o
);

  assert_home_R1: assert property (@(posedge clk)
    rst |=> (mode_oh_o == 6'b000001) && !overlap_err_o);

  assert_idle_func_R2: assert property (@(posedge clk) disable iff (rst)
    !test_mode_i |=> mode_oh_o == 6'b000001);

  assert_bist_pick_R3: assert property (@(posedge clk) disable iff (rst)
    test_mode_i && bist_en_i |=>
      mode_oh_o == ($past(bist_logic_i) ? 6'b010000 : 6'b001000));

  assert_bscan_pick_R4: assert property (@(posedge clk) disable iff (rst)
    test_mode_i && !bist_en_i && (bnd_cls_i != '0) |=> mode_oh_o == 6'b100000);

  assert_shift_pick_R5: assert property (@(posedge clk) disable iff (rst)
    test_mode_i && !bist_en_i && (bnd_cls_i == '0) && scan_en_i |=> mode_oh_o == 6'b000010);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_oh_o) == 1);

  assert_shift_clock_R8: assert property (@(posedge clk) disable iff (rst)
    mode_oh_o[1] |-> clk_sel_o == 2'd1);

  assert_bscan_reset_R9: assert property (@(posedge clk) disable iff (rst)
    mode_oh_o[5] |-> rst_sel_o == 2'd2);

  assert_lbist_path_R10: assert property (@(posedge clk) disable iff (rst)
    mode_oh_o[4] |-> dp_sel_o == 3'd3);

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (rst)
    test_mode_i && bist_en_i && (scan_en_i || bnd_cls_i != '0) |=> overlap_err_o);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    overlap_err_o |=> overlap_err_o);

endmodule

bind dft_mode_ctrl dftm_checker #(.BND_W(BND_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .test_mode_i  (test_mode_i),
  .scan_en_i    (scan_en_i),
  .bist_en_i    (bist_en_i),
  .bist_logic_i (bist_logic_i),
  .bnd_cls_i    (bnd_cls_i),
  .mode_oh_o    (mode_oh_o),
  .clk_sel_o    (clk_sel_o),
  .rst_sel_o    (rst_sel_o),
  .dp_sel_o     (dp_sel_o),
  .overlap_err_o(overlap_err_o)
);

// File: tb/test_dft_mode_ctrl.sv
`timescale 1ns/1ps
module test_dft_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tm = 1'b0, se = 1'b0, be = 1'b0, bl = 1'b0;
  logic [1:0] bc = 2'd0;
  logic [5:0] mode;
  logic [1:0] cks, rss;
  logic [2:0] dps;
  logic       err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_flag = 0;

  always #2.5 clk = ~clk;

  dft_mode_ctrl i_dft_mode_ctrl (
    .clk(clk), .rst(rst), .test_mode_i(tm), .scan_en_i(se), .bist_en_i(be),
    .bist_logic_i(bl), .bnd_cls_i(bc), .mode_oh_o(mode), .clk_sel_o(cks),
    .rst_sel_o(rss), .dp_sel_o(dps), .overlap_err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference priority from the requirements
  function automatic int ref_mode(logic t, logic s, logic b, logic l, logic [1:0] c);
    if (!t)        return 0;
    if (b)         return l ? 4 : 3;
    if (c != 2'd0) return 5;
    if (s)         return 1;
    return 2;
  endfunction

  function automatic int ref_clk(int m);
    case (m) 1: return 1; 3, 4: return 2; 5: return 3; default: return 0; endcase
  endfunction
  function automatic int ref_rst(int m);
    case (m) 0: return 0; 5: return 2; default: return 1; endcase
  endfunction
  function automatic int ref_dp(int m);
    case (m) 1: return 1; 3: return 2; 4: return 3; 5: return 4; default: return 0; endcase
  endfunction

  task automatic drive(input int v);
    tm = v[5]; se = v[4]; be = v[3]; bl = v[2]; bc = v[1:0];
  endtask

  task automatic check_mode(input string req, input int m);
    check({req, " mode"}, int'(mode), 1 << m);
    check({req, " R6 onehot"}, $countones(mode), 1);
    check({req, " R8 clk"}, int'(cks), ref_clk(m));
    check({req, " R9 rst"}, int'(rss), ref_rst(m));
    check({req, " R10 dp"}, int'(dps), ref_dp(m));
  endtask

  // R1: reset with an overlapping combination on the inputs
  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; drive(6'b111111);
    @(negedge clk);
    check_mode("R1 reset", 0);
    check("R1 flag", int'(err), 0);
    rst = 1'b0; drive(0);
    exp_flag = 0;
    @(negedge clk);
  endtask

  // R2..R6, R8..R11: every combination, flag modelled as sticky
  task automatic t_sweep;
    for (int v = 0; v < 64; v++) begin
      int m;
      @(negedge clk);
      drive(v);
      m = ref_mode(tm, se, be, bl, bc);
      if (tm && be && (se || bc != 2'd0)) exp_flag = 1;
      @(negedge clk);
      check_mode(v[5] ? "R3/R4/R5 sweep" : "R2 sweep", m);
      check("R11 sweep flag", int'(err), int'(exp_flag));
    end
  endtask

  // R11: flag holds through legal inputs, only reset clears it
  task automatic t_sticky;
    t_reset();
    drive(6'b111000);           // tm, se, be: overlap
    @(negedge clk);
    check("R11 raised", int'(err), 1);
    check_mode("R3 self-test wins over shift", 3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive(6'b100000);         // legal capture
      @(negedge clk);
      check("R11 held", int'(err), 1);
    end
    t_reset();
    check("R11 cleared by reset", int'(err), 0);
  endtask

  // R7: mid-cycle change has no effect before the edge; R2 return home
  task automatic t_timing;
    @(negedge clk);
    drive(6'b110000);           // shift
    @(negedge clk);
    check_mode("R5 shift", 1);
    drive(6'b101100);           // logic self-test, changed mid-cycle
    #1;
    check("R7 no change before edge", int'(mode), 1 << 1);
    @(negedge clk);
    check_mode("R3 logic self-test", 4);
    drive(6'b010110);           // test off, other controls active
    #1;
    check("R7 held", int'(mode), 1 << 4);
    @(negedge clk);
    check_mode("R2 back to functional", 0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_sticky();
    t_timing();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule